// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a fixed 8192 Hz base tick into a periodic interrupt event whose rate comes from a 4-bit rate code. Each periodic event raises a one-cycle pulse that sets the periodic flag. If the interrupt enable is high in the same cycle, a second pulse also sets the interrupt-request flag. The register file that holds these flags sits outside this block and only consumes the pulses.

The rate table is not monotonic. Code 0 gives no periodic flags. Codes 1 and 2 give the slow rates 256 Hz and 128 Hz. Codes 3 to 15 start at the full base rate and halve at each step, ending at 2 Hz. Code 0 still drives the internal divider at the base rate.

Every periodic event also advances a per-second counter, and this happens even under code 0. Whenever that counter has seen a full second of events, the block emits an update strobe, unless the hold input is high. Any change of the rate code restarts both the divider and the per-second counter.

All pins are plain control and status signals. There is no data stream and therefore no handshake.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pflag_set`, `irq_set` and `sec_strobe` are all 0.
- R2: With rate code 0 selected, `pflag_set` and `irq_set` never pulse.
- R3: Code 1 produces one periodic event every 32 base ticks, and code 2 produces one every 64 base ticks.
- R4: A code c from 3 to 15 produces one periodic event every 2^(c-3) base ticks. Code 3 therefore fires on every tick and code 15 fires every 4096 ticks.
- R5: A cycle in which `rate_sel` differs from the code held since the previous cycle is a restart. In a restart cycle any tick is ignored and no event occurs. The first event under the new code comes on the P-th tick after the restart, where P is the new period.
- R6: `irq_set` pulses only together with `pflag_set`, and only when `pie` was high in the event's tick cycle.
- R7: The per-second counter advances on every event. The counter includes code-0 events, which occur once per tick. When it reaches the rate's frequency (8192/P), it wraps and `sec_strobe` pulses. At a steady code, this is once every 8192 ticks.
- R8: A restart clears the per-second counter.
- R9: If `hold_upd` is high in the tick cycle that completes a second, `sec_strobe` does not pulse, but the counter still wraps.
- R10: Every output pulse appears in the cycle right after a cycle with `base_tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle strobe at the 8192 Hz base rate |
| rate_sel | input | 4 | Rate code |
| pie | input | 1 | Periodic interrupt enable |
| hold_upd | input | 1 | Suppresses the once-per-second update strobe |
| pflag_set | output | 1 | Pulse: set the periodic flag |
| irq_set | output | 1 | Pulse: set the interrupt-request flag and raise the interrupt |
| sec_strobe | output | 1 | Pulse: once-per-second update |

## Verification
The in-RTL assertions check several rules on every cycle. Pulses must follow a tick. No flag may appear under code 0, or in the cycle after a restart. The request pulse must be tied to the flag pulse and to the enable, and the strobe must respect the hold. The divider and per-second counters must stay inside their reload and limit bounds.

The exact periods of each rate code, the phase after a restart mid-count, the clearing of the per-second count, and the one-per-8192-tick strobe cadence are different. These rules are about counts over long windows, so only the bench's reference model and its scenario tallies can show them.

// File: rtl/periodic_irq_pkg.sv
package periodic_irq_pkg;
  localparam int RATE_W = 4;
  typedef logic [RATE_W-1:0] rate_t;

  // log2 of the number of base ticks per periodic event
  function automatic int unsigned period_log2(input rate_t code,
                                              input int unsigned base_log2,
                                              input int unsigned slow_a_log2,
                                              input int unsigned slow_b_log2);
    int unsigned r;
    case (code)
      4'd0:    r = 0;
      4'd1:    r = base_log2 - slow_a_log2;
      4'd2:    r = base_log2 - slow_b_log2;
      default: r = int'(code) - 3;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pig_rate_decode.sv
module pig_rate_decode
  import periodic_irq_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 13,
  parameter int unsigned SLOW_A_LOG2 = 8,
  parameter int unsigned SLOW_B_LOG2 = 7,
  localparam int DIV_W = BASE_LOG2,
  localparam int LIM_W = BASE_LOG2 + 1
) (
  input  rate_t            code,
  output logic [DIV_W-1:0] reload,
  output logic [LIM_W-1:0] evt_limit,
  output logic             flag_en
);
  int unsigned plog;

  always_comb begin
    plog      = period_log2(code, BASE_LOG2, SLOW_A_LOG2, SLOW_B_LOG2);
    reload    = DIV_W'((64'd1 << plog) - 64'd1);
    evt_limit = LIM_W'(64'd1 << (BASE_LOG2 - plog));
    flag_en   = (code != '0);
  end
endmodule

// File: rtl/pig_tick_divider.sv
module pig_tick_divider #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] reload,
  output logic             evt
);
  logic [DIV_W-1:0] cnt;

  assign evt = tick && !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= reload;
    else if (tick) begin
      if (cnt == '0)     cnt <= reload;
      else               cnt <= cnt - 1'b1;
    end
  end

  // R4: with a stable code the phase never exceeds the reload value
  assert_cnt_within_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt <= reload));
endmodule

// File: rtl/pig_second_counter.sv
module pig_second_counter #(
  parameter int LIM_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             evt,
  input  logic [LIM_W-1:0] limit,
  output logic             wrap
);
  logic [LIM_W-1:0] cnt;
  logic [LIM_W-1:0] nxt;

  assign nxt  = cnt + 1'b1;
  assign wrap = evt && (nxt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (evt)     cnt <= wrap ? '0 : nxt;
  end

  // R7: the event count stays below the current frequency
  assert_evt_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt < limit));
  // R8: a restart leaves the counter at zero
  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import periodic_irq_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 13,
  parameter int unsigned SLOW_A_LOG2 = 8,
  parameter int unsigned SLOW_B_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic [3:0] rate_sel,
  input  logic       pie,
  input  logic       hold_upd,
  output logic       pflag_set,
  output logic       irq_set,
  output logic       sec_strobe
);
  localparam int DIV_W = BASE_LOG2;
  localparam int LIM_W = BASE_LOG2 + 1;

  rate_t            rate_q;
  logic             rate_change;
  logic [DIV_W-1:0] reload;
  logic [LIM_W-1:0] evt_limit;
  logic             flag_en;
  logic             evt;
  logic             sec_wrap;

  assign rate_change = (rate_sel != rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else        rate_q <= rate_sel;
  end

  pig_rate_decode #(
    .BASE_LOG2  (BASE_LOG2),
    .SLOW_A_LOG2(SLOW_A_LOG2),
    .SLOW_B_LOG2(SLOW_B_LOG2)
  ) u_dec (
    .code     (rate_sel),
    .reload   (reload),
    .evt_limit(evt_limit),
    .flag_en  (flag_en)
  );

  pig_tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(rate_change),
    .tick   (base_tick),
    .reload (reload),
    .evt    (evt)
  );

  pig_second_counter #(.LIM_W(LIM_W)) u_sec (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(rate_change),
    .evt    (evt),
    .limit  (evt_limit),
    .wrap   (sec_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pflag_set  <= 1'b0;
      irq_set    <= 1'b0;
      sec_strobe <= 1'b0;
    end else begin
      pflag_set  <= evt && flag_en;
      irq_set    <= evt && flag_en && pie;
      sec_strobe <= sec_wrap && !hold_upd;
    end
  end

  // R2: no periodic flag from code 0
  assert_no_flag_code0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pflag_set |-> ($past(rate_sel) != 4'd0));
  // R6: request only with flag and enable
  assert_irq_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (pflag_set && $past(pie)));
  // R9: hold suppresses the update strobe
  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> !$past(hold_upd));
  // R10: every pulse follows a tick
  assert_pulse_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag_set || irq_set || sec_strobe) |-> $past(base_tick));
  // R5: nothing fires out of a restart cycle
  assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_change) |-> (!pflag_set && !sec_strobe));
endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie = 1'b0;
  logic       hold_upd = 1'b0;
  logic       pflag_set, irq_set, sec_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  int n_pf = 0, n_irq = 0, n_sec = 0;
  string cur_req = "R1";

  // reference model state
  int m_rate = 0, m_phase = 0, m_evt = 0;
  bit e_pf = 0, e_irq = 0, e_sec = 0;

  always #5 clk = ~clk;

  periodic_irq_gen dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
    .pie(pie), .hold_upd(hold_upd), .pflag_set(pflag_set), .irq_set(irq_set),
    .sec_strobe(sec_strobe)
  );

  function automatic int ref_period(int c);
    if (c == 0) return 1;
    if (c == 1) return 32;
    if (c == 2) return 64;
    return 1 << (c - 3);
  endfunction

  function automatic int ref_freq(int c);
    return 8192 / ref_period(c);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate = 0; m_phase = 0; m_evt = 0;
      e_pf = 0; e_irq = 0; e_sec = 0;
    end else begin
      e_pf = 0; e_irq = 0; e_sec = 0;
      if (int'(rate_sel) != m_rate) begin
        m_rate = int'(rate_sel); m_phase = 0; m_evt = 0;
      end else if (base_tick) begin
        m_phase++;
        if (m_phase == ref_period(m_rate)) begin
          m_phase = 0;
          e_pf  = (m_rate != 0);
          e_irq = e_pf && pie;
          m_evt++;
          if (m_evt == ref_freq(m_rate)) begin
            m_evt = 0;
            e_sec = !hold_upd;
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus pulse tallies
  always @(negedge clk) begin
    chk(cur_req, {pflag_set, irq_set, sec_strobe}, {e_pf, e_irq, e_sec});
    if (pflag_set)  n_pf++;
    if (irq_set)    n_irq++;
    if (sec_strobe) n_sec++;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      base_tick = 1'b1; step();
      base_tick = 1'b0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic set_rate(int c);
    rate_sel = 4'(c); step(); step();
  endtask

  int s_pf, s_irq, s_sec;
  task automatic snap();
    s_pf = n_pf; s_irq = n_irq; s_sec = n_sec;
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cur_req = "R1";
    step(); step();
    chk("R1", {pflag_set, irq_set, sec_strobe}, 0);
    rst_n = 1'b1; step();
    chk("R1", {pflag_set, irq_set, sec_strobe}, 0);

    // code 0: no flags, strobe each 8192 ticks
    cur_req = "R2"; pie = 1'b1; snap();
    ticks(8195, 0); step();
    chk("R2", n_pf - s_pf, 0);
    chk("R7", n_sec - s_sec, 1);

    // code 1 with gaps, enable off
    cur_req = "R3"; pie = 1'b0; set_rate(1); snap();
    ticks(320, 2); step();
    chk("R3", n_pf - s_pf, 10);
    chk("R6", n_irq - s_irq, 0);

    // code 2 with enable on
    cur_req = "R3"; pie = 1'b1; set_rate(2); snap();
    ticks(128, 1); step();
    chk("R3", n_pf - s_pf, 2);
    chk("R6", n_irq - s_irq, 2);

    // fast codes
    cur_req = "R4"; set_rate(3); snap();
    ticks(20, 0); step();
    chk("R4", n_pf - s_pf, 20);
    set_rate(4); snap(); ticks(20, 0); step();
    chk("R4", n_pf - s_pf, 10);
    set_rate(15); snap(); ticks(4100, 0); step();
    chk("R4", n_pf - s_pf, 1);

    // restart mid-phase, tick in the change cycle
    cur_req = "R5"; set_rate(6); ticks(5, 0);
    snap();
    rate_sel = 4'd7; base_tick = 1'b1; step(); base_tick = 1'b0;
    ticks(15, 0); step();
    chk("R5", n_pf - s_pf, 0);
    ticks(1, 0); step();
    chk("R5", n_pf - s_pf, 1);

    // restart clears the per-second count
    cur_req = "R8"; set_rate(3); ticks(8000, 0);
    set_rate(4); snap();
    ticks(8191, 0); step();
    chk("R8", n_sec - s_sec, 0);
    ticks(1, 0); step();
    chk("R8", n_sec - s_sec, 1);

    // hold suppresses strobe, counter keeps wrapping
    cur_req = "R9"; set_rate(3); hold_upd = 1'b1; snap();
    ticks(8192, 0); step();
    chk("R9", n_sec - s_sec, 0);
    hold_upd = 1'b0; snap();
    ticks(8192, 0); step();
    chk("R7", n_sec - s_sec, 1);

    // back-to-back ticks at full rate give pulses each cycle after a tick (R10)
    cur_req = "R10"; snap(); ticks(3, 0); step();
    chk("R10", n_pf - s_pf, 3);

    step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule